// File: doc/BRIEF.md
# Card Command Issuer with Response Capture

This block sends one command to a memory card and collects what the card sends back. Software, or a bus decoder in front of the block, loads an argument word and then a command word. The command word carries a 6-bit command index and a handful of control bits. When the word asks for execution, the block hands the index and the argument to the card-side engine as a one-cycle request. It then gathers the reply as a stream of bytes that ends with a done strobe, and that strobe may carry an error flag.

Once the reply is complete, the block checks its length against what the command asked for. A reply that passes is packed into four 32-bit response words, most significant byte first. The block then reports one outcome as a one-cycle pulse on an 8-bit status-set vector, at the bit positions a neighbouring status register decodes. The enable bit of the command register clears itself when handling ends. A `cmd_done` pulse goes out in the same cycle, so a data engine can start once the command is over.

The controller is a five-state machine. IDLE waits for a command write. ISSUE drives the request for one cycle. WAIT collects reply bytes until the done strobe. JUDGE classifies the complete reply. FINISH publishes the result and then leaves. The transitions are:
- go: IDLE or FINISH to ISSUE, on an accepted command write with enable set and pending clear.
- sent: ISSUE to WAIT.
- replied: WAIT to JUDGE, when `rsp_done` is high.
- judged: JUDGE to FINISH.
- rest: FINISH to IDLE, when no new command starts.

Top module: `cmdi_top`

## Requirements
- R1: Command word fields are: bits [5:0] index, bit 6 response expected, bit 7 long response, bit 8 interrupt mode (stored only), bit 9 pending, bit 10 enable. A write with bit 10 set and bit 9 clear, made while not busy, raises `req_valid` for exactly one cycle, in the cycle after the write. During that cycle `req_index` shows bits [5:0] and `req_arg` shows the argument register.
- R2: When a command completes, bit 10 of `cmd_q` reads 0 and bits [9:0] keep their written value.
- R3: A write with both bit 10 and bit 9 set issues no request, gives no status pulse and does not make the block busy. In the next cycle `cmd_q` holds the written word with bit 10 cleared.
- R4: With bit 6 set, the reply is a timeout in three cases: the reply has 0 bytes, it has 4 bytes while bit 7 is set, or its length is neither 4 nor 16 bytes.
- R5: An accepted reply is packed big-endian. Reply byte 4w+k lands in bits [31-8k:24-8k] of response word w, so the first byte is in bits [31:24] of word 0.
- R6: An accepted 4-byte reply sets words 1 to 3 to zero. An accepted 16-byte reply has bit 0 of word 3 forced to 0.
- R7: In the `cmd_done` cycle exactly one bit of `stat_set` is high. Bit 6 means a response was accepted, bit 7 means a command with bit 6 clear was sent, and bit 2 means a timeout. In every other cycle `stat_set` is zero.
- R8: `rsp_err` sampled with `rsp_done` gives a timeout whatever the length. After any timeout the response words are unchanged.
- R9: `busy` is high from the cycle after an executing command write until the `cmd_done` cycle, and low in that cycle. Command writes made while `busy` is high are ignored: no request is issued and bits [9:0] of `cmd_q` do not change.
- R10: After reset, the argument, the command register and all response words are zero, and `busy`, `req_valid`, `cmd_done` and `stat_set` are low.
- R11: A byte is taken when `rsp_valid` is high in any cycle from the one after the request up to and including the `rsp_done` cycle. `cmd_done` is a single-cycle pulse in the second cycle after the `rsp_done` cycle, and the response words take their new values in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arg_wr | input | 1 | Write strobe for the argument register |
| arg_wdata | input | 32 | Argument write data |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 11 | Command write data |
| arg_q | output | 32 | Argument register contents |
| cmd_q | output | 11 | Command register contents |
| req_valid | output | 1 | One-cycle request to the card engine |
| req_index | output | 6 | Command index shown with the request |
| req_arg | output | 32 | Argument shown with the request |
| rsp_valid | input | 1 | A reply byte is present |
| rsp_byte | input | 8 | Reply byte |
| rsp_done | input | 1 | The reply is complete |
| rsp_err | input | 1 | The card engine reports a failure (sampled with rsp_done) |
| rsp_words | output | 4x32 | Response words 0 to 3 |
| busy | output | 1 | A command is in flight |
| cmd_done | output | 1 | One-cycle completion pulse |
| stat_set | output | 8 | One-cycle status set pulse (bits 2, 6, 7) |

## Verification
Every result has a fixed latency. The request is due one cycle after the command write, and a pending write shows its cleared enable bit one cycle after the write. The `cmd_done` pulse, the status pulse, the new response words and the cleared enable bit all fall in the second cycle after `rsp_done`, and the busy flag drops in that same cycle. Each scenario task drives its inputs on falling edges and samples at the falling edge of exactly those cycles. It also samples the cycle just before completion and the cycle just after it, to show that the pulse lasts one cycle and is not early.

// File: rtl/cmdi_pkg.sv
package cmdi_pkg;
    localparam int CMD_W      = 11;
    localparam int IDX_W      = 6;
    localparam int BIT_RESP   = 6;
    localparam int BIT_LONG   = 7;
    localparam int BIT_PEND   = 9;
    localparam int BIT_EN     = 10;
    localparam int STAT_W     = 8;
    localparam int ST_TIMEOUT = 2;
    localparam int ST_RESP    = 6;
    localparam int ST_SENT    = 7;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_JUDGE,
        S_FINISH
    } cmdi_state_e;

    typedef enum logic [1:0] {
        V_NONE,
        V_RESP,
        V_SENT,
        V_TIMEOUT
    } cmdi_verdict_e;
endpackage

// File: rtl/cmdi_byte_buf.sv
module cmdi_byte_buf #(
    parameter int MAX_BYTES = 16,
    parameter int CNT_W     = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      wr_en,
    input  logic [7:0]                wr_byte,
    output logic [MAX_BYTES-1:0][7:0] bytes,
    output logic [CNT_W-1:0]          count
);
    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (wr_en && count != CNT_SAT) begin
            count <= count + 1'b1;
        end
    end

    for (genvar i = 0; i < MAX_BYTES; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bytes[i] <= '0;
            end else if (wr_en && count == CNT_W'(i)) begin
                bytes[i] <= wr_byte;
            end
        end
    end

    // R11: the byte count only grows between clears
    assert_count_monotonic_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> count >= $past(count));
endmodule

// File: rtl/cmdi_verdict.sv
module cmdi_verdict
    import cmdi_pkg::*;
#(
    parameter int CNT_W     = 6,
    parameter int SHORT_LEN = 4,
    parameter int LONG_LEN  = 16
) (
    input  logic             card_err,
    input  logic             want_resp,
    input  logic             want_long,
    input  logic [CNT_W-1:0] count,
    output cmdi_verdict_e    verdict,
    output logic             is_short
);
    localparam logic [CNT_W-1:0] SHORT_C = CNT_W'(SHORT_LEN);
    localparam logic [CNT_W-1:0] LONG_C  = CNT_W'(LONG_LEN);

    logic bad_len;

    always_comb begin
        is_short = (count == SHORT_C);
        bad_len  = (count == '0) || (want_long && is_short)
                || (!is_short && count != LONG_C);
        if (card_err) begin
            verdict = V_TIMEOUT;
        end else if (!want_resp) begin
            verdict = V_SENT;
        end else if (bad_len) begin
            verdict = V_TIMEOUT;
        end else begin
            verdict = V_RESP;
        end
    end
endmodule

// File: rtl/cmdi_packer.sv
module cmdi_packer #(
    parameter int RSP_WORDS = 4,
    parameter int WORD_W    = 32
) (
    input  logic [RSP_WORDS*(WORD_W/8)-1:0][7:0] bytes,
    input  logic                                 is_short,
    output logic [RSP_WORDS-1:0][WORD_W-1:0]     words
);
    localparam int BPW = WORD_W / 8;

    logic [RSP_WORDS-1:0][WORD_W-1:0] raw;

    for (genvar w = 0; w < RSP_WORDS; w++) begin : g_word
        for (genvar k = 0; k < BPW; k++) begin : g_byte
            assign raw[w][WORD_W-1-8*k -: 8] = bytes[w*BPW + k];
        end
    end

    always_comb begin
        for (int w = 0; w < RSP_WORDS; w++) begin
            words[w] = (is_short && w != 0) ? '0 : raw[w];
        end
        if (!is_short) begin
            words[RSP_WORDS-1][0] = 1'b0;
        end
    end
endmodule

// File: rtl/cmdi_top.sv
module cmdi_top
    import cmdi_pkg::*;
#(
    parameter int ARG_W     = 32,
    parameter int WORD_W    = 32,
    parameter int RSP_WORDS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              arg_wr,
    input  logic [ARG_W-1:0]                  arg_wdata,
    input  logic                              cmd_wr,
    input  logic [CMD_W-1:0]                  cmd_wdata,
    output logic [ARG_W-1:0]                  arg_q,
    output logic [CMD_W-1:0]                  cmd_q,
    output logic                              req_valid,
    output logic [IDX_W-1:0]                  req_index,
    output logic [ARG_W-1:0]                  req_arg,
    input  logic                              rsp_valid,
    input  logic [7:0]                        rsp_byte,
    input  logic                              rsp_done,
    input  logic                              rsp_err,
    output logic [RSP_WORDS-1:0][WORD_W-1:0]  rsp_words,
    output logic                              busy,
    output logic                              cmd_done,
    output logic [STAT_W-1:0]                 stat_set
);
    localparam int BPW       = WORD_W / 8;
    localparam int MAX_BYTES = RSP_WORDS * BPW;
    localparam int CNT_W     = $clog2(MAX_BYTES) + 2;

    cmdi_state_e   state, state_nx;
    cmdi_verdict_e verdict, verdict_q;
    logic          err_q;
    logic          accept;
    logic          is_short;
    logic [CNT_W-1:0]                 count;
    logic [MAX_BYTES-1:0][7:0]        bytes;
    logic [RSP_WORDS-1:0][WORD_W-1:0] packed_words;

    assign accept    = cmd_wr && !busy;
    assign req_index = cmd_q[IDX_W-1:0];
    assign req_arg   = arg_q;

    cmdi_byte_buf #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .clr(state == S_ISSUE),
        .wr_en(state == S_WAIT && rsp_valid),
        .wr_byte(rsp_byte),
        .bytes(bytes), .count(count)
    );

    cmdi_verdict #(.CNT_W(CNT_W), .SHORT_LEN(BPW), .LONG_LEN(MAX_BYTES)) u_verdict (
        .card_err(err_q),
        .want_resp(cmd_q[BIT_RESP]),
        .want_long(cmd_q[BIT_LONG]),
        .count(count),
        .verdict(verdict),
        .is_short(is_short)
    );

    cmdi_packer #(.RSP_WORDS(RSP_WORDS), .WORD_W(WORD_W)) u_pack (
        .bytes(bytes), .is_short(is_short), .words(packed_words)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE, S_FINISH: begin
                if (accept && cmd_wdata[BIT_EN] && !cmd_wdata[BIT_PEND]) state_nx = S_ISSUE;
                else state_nx = S_IDLE;
            end
            S_ISSUE:  state_nx = S_WAIT;
            S_WAIT:   if (rsp_done) state_nx = S_JUDGE;
            S_JUDGE:  state_nx = S_FINISH;
            default:  state_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arg_q     <= '0;
            cmd_q     <= '0;
            err_q     <= 1'b0;
            verdict_q <= V_NONE;
            rsp_words <= '0;
        end else begin
            if (arg_wr) arg_q <= arg_wdata;
            if (accept) begin
                cmd_q <= cmd_wdata;
                if (cmd_wdata[BIT_PEND]) cmd_q[BIT_EN] <= 1'b0;
            end else if (state == S_JUDGE) begin
                cmd_q[BIT_EN] <= 1'b0;
            end
            if (state == S_WAIT && rsp_done) err_q <= rsp_err;
            if (state == S_JUDGE) begin
                verdict_q <= verdict;
                if (verdict == V_RESP) rsp_words <= packed_words;
            end
        end
    end

    // outputs from state
    always_comb begin
        req_valid = 1'b0;
        busy      = 1'b0;
        cmd_done  = 1'b0;
        stat_set  = '0;
        unique case (state)
            S_IDLE:  ;
            S_ISSUE: begin req_valid = 1'b1; busy = 1'b1; end
            S_WAIT:  busy = 1'b1;
            S_JUDGE: busy = 1'b1;
            S_FINISH: begin
                cmd_done = 1'b1;
                unique case (verdict_q)
                    V_RESP:    stat_set[ST_RESP]    = 1'b1;
                    V_SENT:    stat_set[ST_SENT]    = 1'b1;
                    V_TIMEOUT: stat_set[ST_TIMEOUT] = 1'b1;
                    default:   ;
                endcase
            end
            default: ;
        endcase
    end

    // R1: a request only follows a command write
    assert_req_after_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(cmd_wr));
    // R2: enable bit reads clear at completion
    assert_enable_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !cmd_q[BIT_EN]);
    // R6: accepted reply never shows bit 0 of the last word set
    assert_last_lsb_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && stat_set[ST_RESP] && !$stable(rsp_words[1])) |-> !rsp_words[RSP_WORDS-1][0]);
    // R7: exactly one status bit with completion, none otherwise
    assert_one_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> $countones(stat_set) == 1);
    assert_no_stray_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |-> stat_set == '0);
    // R8: a timeout leaves the response words alone
    assert_timeout_keeps_words_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && stat_set[ST_TIMEOUT]) |-> $stable(rsp_words));
    // R9: writes while busy do not alter the stored command fields
    assert_busy_ignores_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> cmd_q[BIT_PEND:0] == $past(cmd_q[BIT_PEND:0]));
endmodule

// File: tb/sim_cmdi_top.sv
module sim_cmdi_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              arg_wr = 1'b0;
    logic [31:0]       arg_wdata = '0;
    logic              cmd_wr = 1'b0;
    logic [10:0]       cmd_wdata = '0;
    logic [31:0]       arg_q;
    logic [10:0]       cmd_q;
    logic              req_valid;
    logic [5:0]        req_index;
    logic [31:0]       req_arg;
    logic              rsp_valid = 1'b0;
    logic [7:0]        rsp_byte = '0;
    logic              rsp_done = 1'b0;
    logic              rsp_err = 1'b0;
    logic [3:0][31:0]  rsp_words;
    logic              busy;
    logic              cmd_done;
    logic [7:0]        stat_set;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [7:0]  bb [0:19];
    logic [31:0] mw [0:3];

    cmdi_top u0 (
        .clk(clk), .rst_n(rst_n),
        .arg_wr(arg_wr), .arg_wdata(arg_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .arg_q(arg_q), .cmd_q(cmd_q),
        .req_valid(req_valid), .req_index(req_index), .req_arg(req_arg),
        .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
        .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_words(rsp_words), .busy(busy),
        .cmd_done(cmd_done), .stat_set(stat_set)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_words(input string req);
        for (int i = 0; i < 4; i++) begin
            chk(rsp_words[i] == mw[i], req, rsp_words[i], mw[i]);
        end
    endtask

    task automatic fill(input logic [7:0] seed);
        for (int i = 0; i < 20; i++) bb[i] = seed + 8'(i * 17);
    endtask

    // full command: write, request, n bytes, done, judge, finish
    task automatic run_cmd(input logic [10:0] w, input logic [31:0] a, input int n,
                           input logic err, input logic done_on_last, input logic poke);
        logic [7:0] exp_stat;
        logic want_resp = w[6];
        logic want_long = w[7];
        if (err) exp_stat = 8'h04;
        else if (!want_resp) exp_stat = 8'h80;
        else if (n == 0 || (want_long && n == 4) || (n != 4 && n != 16)) exp_stat = 8'h04;
        else exp_stat = 8'h40;
        @(negedge clk);
        arg_wr = 1'b1; arg_wdata = a; cmd_wr = 1'b1; cmd_wdata = w;
        @(negedge clk);
        arg_wr = 1'b0; cmd_wr = 1'b0;
        chk(req_valid == 1'b1, "R1 req_valid", req_valid, 1);
        chk(req_index == w[5:0], "R1 req_index", req_index, w[5:0]);
        chk(req_arg == a, "R1 req_arg", req_arg, a);
        chk(busy == 1'b1, "R9 busy after write", busy, 1);
        @(negedge clk);
        chk(req_valid == 1'b0, "R1 req one cycle", req_valid, 0);
        for (int i = 0; i < n; i++) begin
            rsp_valid = 1'b1; rsp_byte = bb[i];
            if (poke && i == 0) begin cmd_wr = 1'b1; cmd_wdata = 11'h4FF; end
            if (done_on_last && i == n-1) begin rsp_done = 1'b1; rsp_err = err; end
            @(negedge clk);
            if (poke && i == 0) begin
                cmd_wr = 1'b0;
                chk(cmd_q == w, "R9 write ignored while busy", cmd_q, w);
                chk(req_valid == 1'b0, "R9 no request while busy", req_valid, 0);
            end
        end
        rsp_valid = 1'b0;
        if (!(done_on_last && n > 0)) begin
            rsp_done = 1'b1; rsp_err = err;
            @(negedge clk);
        end
        rsp_done = 1'b0; rsp_err = 1'b0;
        chk(cmd_done == 1'b0, "R11 no early done", cmd_done, 0);
        chk(busy == 1'b1, "R9 busy before done", busy, 1);
        @(negedge clk);
        if (exp_stat == 8'h40) begin
            for (int k = 0; k < 4; k++) begin
                mw[k] = (n == 4 && k != 0) ? 32'h0 : {bb[4*k], bb[4*k+1], bb[4*k+2], bb[4*k+3]};
            end
            if (n == 16) mw[3][0] = 1'b0;
        end
        chk(cmd_done == 1'b1, "R11 done pulse", cmd_done, 1);
        chk(stat_set == exp_stat, "R7 status", stat_set, exp_stat);
        chk(busy == 1'b0, "R9 busy low at done", busy, 0);
        chk(cmd_q == (w & 11'h3FF), "R2 enable cleared", cmd_q, w & 11'h3FF);
        chk_words("R5 R6 R8 words");
        @(negedge clk);
        chk(cmd_done == 1'b0, "R11 done single cycle", cmd_done, 0);
        chk(stat_set == 8'h00, "R7 status single cycle", stat_set, 0);
    endtask

    task automatic t_reset;
        chk(arg_q == '0, "R10 arg", arg_q, 0);
        chk(cmd_q == '0, "R10 cmd", cmd_q, 0);
        chk(busy == 1'b0 && req_valid == 1'b0, "R10 busy/req", {busy, req_valid}, 0);
        chk(cmd_done == 1'b0 && stat_set == 8'h00, "R10 done/status", {cmd_done, stat_set}, 0);
        chk_words("R10 words");
    endtask

    task automatic t_pending;
        @(negedge clk);
        cmd_wr = 1'b1; cmd_wdata = 11'h655;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk(req_valid == 1'b0, "R3 no request", req_valid, 0);
        chk(busy == 1'b0, "R3 not busy", busy, 0);
        chk(cmd_q == 11'h255, "R3 enable cleared", cmd_q, 11'h255);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(cmd_done == 1'b0 && stat_set == 8'h00, "R3 no status", {cmd_done, stat_set}, 0);
        end
        chk_words("R3 words untouched");
    endtask

    initial begin
        for (int i = 0; i < 4; i++) mw[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        fill(8'h5A); run_cmd(11'h451, 32'hCAFE0001, 4, 1'b0, 1'b0, 1'b0);  // R5 short
        fill(8'h20); run_cmd(11'h4C2, 32'h00000002, 16, 1'b0, 1'b1, 1'b0); // R6 long, done on last byte
        fill(8'h91); run_cmd(11'h443, 32'h00000003, 4, 1'b0, 1'b0, 1'b0);  // R6 short zeroes tail
        fill(8'h07); run_cmd(11'h4C4, 32'h00000004, 4, 1'b0, 1'b0, 1'b0);  // R4 long asked, 4 bytes
        run_cmd(11'h445, 32'h00000005, 0, 1'b0, 1'b0, 1'b0);               // R4 zero length
        fill(8'h33); run_cmd(11'h446, 32'h00000006, 8, 1'b0, 1'b0, 1'b0);  // R4 length 8
        fill(8'h44); run_cmd(11'h407, 32'h00000007, 0, 1'b0, 1'b0, 1'b0);  // R7 no response
        fill(8'h55); run_cmd(11'h448, 32'h00000008, 4, 1'b1, 1'b0, 1'b0);  // R8 card error
        t_pending();                                                        // R3
        fill(8'h66); run_cmd(11'h54A, 32'h0000000A, 4, 1'b0, 1'b0, 1'b1);  // R9 busy write, bit 8 stored
        fill(8'h12); run_cmd(11'h44B, 32'h0000000B, 16, 1'b0, 1'b0, 1'b0); // R4 short asked, 16 ok
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule